// File: doc/BRIEF.md
# Multi-Line SPI Command Master

This block is an SPI master that plays out a short, pre-loaded list of command words to as many as fifteen peripherals that share one serial clock and one data line, such as a bank of threshold DACs. Software fills up to sixteen command slots through a small register bus. It chooses which chip-select lines take part, sets the word length and the serial clock rate, and then writes a start bit. The block then sends the slots in order, from slot 0 up to the programmed count. It captures the return data on the input line and holds the bits of the last word for readback.

Each output line has its own disable and invert control, separately for the serial clock, the data out and the chip select. The same engine can therefore serve parts with different idle polarities. A lock bit reserves the lines for other use. While it is set, the block starts nothing on its own. A clear output follows a register bit and can be wired to the clear input of a device. While a sequence is running the register file accepts no writes, so a sequence always runs to its end.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset, every SCK, SDO and CS output is low and busy is low. The word-length register (address 0x19) reads 32, the half-period register (address 0x1A) reads 7, and the control, chip-select and line-control registers read 0.
- R2: Addresses 0x00 to 0x0F each hold one 32-bit command word, which can be written and read back.
- R3: A write to the control register (address 0x11) sets the slot count minus one from bits 3..0. If bit 31 is set in that write, the block sends slots 0 through count-1 in order. Busy reads as bit 31 of the control register and is also a port. Busy rises on the clock edge that accepts the write and falls after the final half period of the last word.
- R4: Each half period lasts (half-period value + 1) system clocks. A word of N bits takes 2N+2 half periods. CS is active in the first 2N+1 of them and inactive in the last. SCK is high in half periods 1, 3, …, 2N-1 and low in all the others.
- R5: Data goes out MSB first in SPI mode 0. SDO shows the bit for half periods 2k and 2k+1, changes only as SCK falls, and keeps bit 0 through half period 2N. Bits at and above the word length are never sent.
- R6: SDI is sampled as SCK rises. The readback register (address 0x12) holds the last completed word, right-aligned, with zeros above the word length.
- R7: Chip-select register (address 0x10): bit i set means CS line i is active during the transfer.
- R8: Line control registers are at 0x15 (SDO), 0x16 (SCK) and 0x17 (CS). In each one, bit i disables line i, which forces it to the low idle level, and bit 16+i inverts line i after that gating.
- R9: While busy is high, every register write is ignored.
- R10: Lock register (address 0x13), bit 0: while it is set, a start request is ignored and all lines stay idle.
- R11: Word length (address 0x19) accepts values 1 to 32. Writes outside that range are ignored. The half period (address 0x1A) is 8 bits wide.
- R12: Bit 0 of the clear register (address 0x14) drives the clear output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| spi_sdi | input | 1 | Serial data from peripherals |
| spi_sck | output | 15 | Serial clock, one per line |
| spi_sdo | output | 15 | Serial data out, one per line |
| spi_cs | output | 15 | Chip selects, active high before inversion |
| spi_clr | output | 1 | Device clear output |
| busy | output | 1 | Sequence in progress |

## Verification
The bench compares every pin against a behavioural model on every clock. It uses three mixes of word length and clock divider: 32 bits with the fastest clock, a short odd length, and a full sixteen-slot run. If the bit at half period 2N or the trailing CS-off half period were wrong, the bench would see the word lengthened or shortened by one edge. If SDI were sampled on the wrong edge, the readback would come out shifted by one bit. The slot words carry set bits above the word length, so a design that leaked them would send the wrong leading bits. The bench also tries a register write in the middle of a sequence, a start while locked, and out-of-range word lengths. A design that let any of these through would show a changed register or a sequence that should not run.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   localparam int unsigned ADDR_W = 5;

   localparam logic [ADDR_W-1:0] A_CSMASK = 5'h10;
   localparam logic [ADDR_W-1:0] A_CTRL   = 5'h11;
   localparam logic [ADDR_W-1:0] A_RDBK   = 5'h12;
   localparam logic [ADDR_W-1:0] A_LOCK   = 5'h13;
   localparam logic [ADDR_W-1:0] A_CLR    = 5'h14;
   localparam logic [ADDR_W-1:0] A_SDOC   = 5'h15;
   localparam logic [ADDR_W-1:0] A_SCKC   = 5'h16;
   localparam logic [ADDR_W-1:0] A_CSC    = 5'h17;
   localparam logic [ADDR_W-1:0] A_WLEN   = 5'h19;
   localparam logic [ADDR_W-1:0] A_HALF   = 5'h1A;

   localparam int unsigned START_BIT = 31;

   // per-line gating: upper half inverts, lower half disables
   typedef struct packed {
      logic [15:0] inv;
      logic [15:0] dis;
   } line_ctl_t;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
   import spi_cmd_pkg::*;
#(
   parameter int unsigned SLOTS    = 16,
   parameter int unsigned DW       = 32,
   parameter int unsigned PW       = 8,
   parameter int unsigned LINES    = 15,
   parameter int unsigned DEF_HALF = 7,
   localparam int unsigned SIW     = $clog2(SLOTS),
   localparam int unsigned WLW     = $clog2(DW) + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              busy,
   input  logic [SIW-1:0]    eng_idx,
   input  logic [DW-1:0]     readback,
   output logic [DW-1:0]     eng_word,
   output logic [LINES-1:0]  csmask,
   output line_ctl_t         sdo_ctl,
   output line_ctl_t         sck_ctl,
   output line_ctl_t         cs_ctl,
   output logic [WLW-1:0]    wlen,
   output logic [PW-1:0]     half,
   output logic [SIW-1:0]    count_m1,
   output logic              lock,
   output logic              clr,
   output logic              start
);
   localparam logic [15:0] LMASK = 16'((32'd1 << LINES) - 1);

   logic [DW-1:0] slot_q [SLOTS];
   logic          wr_ok;

   assign wr_ok = we && !busy;
   assign start = wr_ok && (addr == A_CTRL) && wdata[START_BIT] && !lock;
   assign eng_word = slot_q[eng_idx];

   function automatic line_ctl_t to_ctl(input logic [31:0] d);
      line_ctl_t c;
      c.inv = d[31:16] & LMASK;
      c.dis = d[15:0]  & LMASK;
      return c;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         csmask   <= '0;
         sdo_ctl  <= '0;
         sck_ctl  <= '0;
         cs_ctl   <= '0;
         wlen     <= WLW'(DW);
         half     <= PW'(DEF_HALF);
         count_m1 <= '0;
         lock     <= 1'b0;
         clr      <= 1'b0;
      end else if (wr_ok) begin
         case (addr)
            A_CSMASK: csmask   <= wdata[LINES-1:0];
            A_CTRL:   count_m1 <= wdata[SIW-1:0];
            A_LOCK:   lock     <= wdata[0];
            A_CLR:    clr      <= wdata[0];
            A_SDOC:   sdo_ctl  <= to_ctl(wdata);
            A_SCKC:   sck_ctl  <= to_ctl(wdata);
            A_CSC:    cs_ctl   <= to_ctl(wdata);
            A_WLEN:   if (wdata >= 32'd1 && wdata <= 32'(DW)) wlen <= wdata[WLW-1:0];
            A_HALF:   half     <= wdata[PW-1:0];
            default:  ;
         endcase
      end
   end

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n)
               slot_q[s] <= '0;
            else if (wr_ok && addr == ADDR_W'(s))
               slot_q[s] <= wdata[DW-1:0];
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (addr < ADDR_W'(SLOTS))
         rdata = 32'(slot_q[addr[SIW-1:0]]);
      else begin
         case (addr)
            A_CSMASK: rdata = 32'(csmask);
            A_CTRL:   rdata = {busy, 31'(count_m1)};
            A_RDBK:   rdata = 32'(readback);
            A_LOCK:   rdata = {31'b0, lock};
            A_CLR:    rdata = {31'b0, clr};
            A_SDOC:   rdata = sdo_ctl;
            A_SCKC:   rdata = sck_ctl;
            A_CSC:    rdata = cs_ctl;
            A_WLEN:   rdata = 32'(wlen);
            A_HALF:   rdata = 32'(half);
            default:  rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
   parameter int unsigned SLOTS = 16,
   parameter int unsigned DW    = 32,
   parameter int unsigned PW    = 8,
   localparam int unsigned SIW  = $clog2(SLOTS),
   localparam int unsigned WLW  = $clog2(DW) + 1,
   localparam int unsigned HW   = WLW + 1
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [SIW-1:0] count_m1,
   input  logic [WLW-1:0] wlen,
   input  logic [PW-1:0]  half,
   input  logic [DW-1:0]  word_in,
   input  logic           sdi,
   output logic [SIW-1:0] word_idx,
   output logic           busy,
   output logic           sck_raw,
   output logic           sdo_raw,
   output logic           cs_raw,
   output logic [DW-1:0]  readback
);
   logic [SIW-1:0] idx_q;
   logic [HW-1:0]  h_q;
   logic [PW-1:0]  tk_q;
   logic [DW-1:0]  tx_q, rx_q;
   logic [HW-1:0]  last_h, two_n;
   logic [DW-1:0]  aligned;

   assign last_h   = {wlen, 1'b1};
   assign two_n    = {wlen, 1'b0};
   assign aligned  = word_in << (WLW'(DW) - wlen);
   assign word_idx = busy ? idx_q + SIW'(1) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         idx_q    <= '0;
         h_q      <= '0;
         tk_q     <= '0;
         tx_q     <= '0;
         rx_q     <= '0;
         readback <= '0;
      end else if (!busy) begin
         if (start) begin
            busy  <= 1'b1;
            idx_q <= '0;
            h_q   <= '0;
            tk_q  <= '0;
            tx_q  <= aligned;
            rx_q  <= '0;
         end
      end else if (tk_q != half) begin
         tk_q <= tk_q + PW'(1);
      end else begin
         tk_q <= '0;
         if (h_q == last_h) begin
            readback <= rx_q;
            if (idx_q == count_m1)
               busy <= 1'b0;
            else begin
               idx_q <= idx_q + SIW'(1);
               h_q   <= '0;
               tx_q  <= aligned;
               rx_q  <= '0;
            end
         end else begin
            h_q <= h_q + HW'(1);
            if (!h_q[0]) begin
               if (h_q != two_n) rx_q <= {rx_q[DW-2:0], sdi};
            end else if (h_q + HW'(1) != two_n) begin
               tx_q <= tx_q << 1;
            end
         end
      end
   end

   assign cs_raw  = busy && (h_q != last_h);
   assign sck_raw = cs_raw && h_q[0];
   assign sdo_raw = cs_raw && tx_q[DW-1];
endmodule

// File: rtl/spi_cmd_lines.sv
module spi_cmd_lines
   import spi_cmd_pkg::*;
#(
   parameter int unsigned LINES   = 15,
   parameter bit          OUT_REG = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw,
   input  logic [LINES-1:0] sel,
   input  line_ctl_t        ctl,
   output logic [LINES-1:0] pins
);
   logic [LINES-1:0] gated;

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_line
         assign gated[i] = (raw & sel[i] & ~ctl.dis[i]) ^ ctl.inv[i];
      end
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) pins <= '0;
            else        pins <= gated;
         end
      end else begin : g_comb
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign pins = gated;
      end
   endgenerate
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
   import spi_cmd_pkg::*;
#(
   parameter int unsigned LINES    = 15,
   parameter int unsigned SLOTS    = 16,
   parameter int unsigned DW       = 32,
   parameter int unsigned PW       = 8,
   parameter int unsigned DEF_HALF = 7,
   parameter bit          OUT_REG  = 1'b0,
   localparam int unsigned SIW     = $clog2(SLOTS),
   localparam int unsigned WLW     = $clog2(DW) + 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              spi_sdi,
   output logic [LINES-1:0]  spi_sck,
   output logic [LINES-1:0]  spi_sdo,
   output logic [LINES-1:0]  spi_cs,
   output logic              spi_clr,
   output logic              busy
);
   generate
      if (LINES < 1 || LINES > 16) begin : g_bad_lines
         $error("LINES must lie in 1..16");
      end
      if (DW < 2 || DW > 32) begin : g_bad_dw
         $error("DW must lie in 2..32");
      end
      if (SLOTS < 2 || SLOTS > 16 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
         $error("SLOTS must be a power of two in 2..16");
      end
      if (PW < 1 || PW > 16) begin : g_bad_pw
         $error("PW must lie in 1..16");
      end
   endgenerate

   logic [SIW-1:0]   word_idx, count_m1;
   logic [DW-1:0]    word_q, readback;
   logic [LINES-1:0] csmask;
   line_ctl_t        sdo_ctl, sck_ctl, cs_ctl;
   logic [WLW-1:0]   wlen;
   logic [PW-1:0]    half;
   logic             lock, start, sck_raw, sdo_raw, cs_raw;

   spi_cmd_regs #(.SLOTS(SLOTS), .DW(DW), .PW(PW), .LINES(LINES), .DEF_HALF(DEF_HALF)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .busy(busy), .eng_idx(word_idx), .readback(readback),
      .eng_word(word_q), .csmask(csmask), .sdo_ctl(sdo_ctl), .sck_ctl(sck_ctl),
      .cs_ctl(cs_ctl), .wlen(wlen), .half(half), .count_m1(count_m1),
      .lock(lock), .clr(spi_clr), .start(start)
   );

   spi_cmd_engine #(.SLOTS(SLOTS), .DW(DW), .PW(PW)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .count_m1(count_m1), .wlen(wlen),
      .half(half), .word_in(word_q), .sdi(spi_sdi), .word_idx(word_idx),
      .busy(busy), .sck_raw(sck_raw), .sdo_raw(sdo_raw), .cs_raw(cs_raw),
      .readback(readback)
   );

   spi_cmd_lines #(.LINES(LINES), .OUT_REG(OUT_REG)) u_sck (
      .clk(clk), .rst_n(rst_n), .raw(sck_raw), .sel('1), .ctl(sck_ctl), .pins(spi_sck));
   spi_cmd_lines #(.LINES(LINES), .OUT_REG(OUT_REG)) u_sdo (
      .clk(clk), .rst_n(rst_n), .raw(sdo_raw), .sel('1), .ctl(sdo_ctl), .pins(spi_sdo));
   spi_cmd_lines #(.LINES(LINES), .OUT_REG(OUT_REG)) u_cs (
      .clk(clk), .rst_n(rst_n), .raw(cs_raw), .sel(csmask), .ctl(cs_ctl), .pins(spi_cs));
endmodule

// File: rtl/spi_cmd_chk.sv
module spi_cmd_chk
   import spi_cmd_pkg::*;
#(
   parameter int unsigned LINES = 15,
   parameter int unsigned DW    = 32,
   parameter int unsigned PW    = 8,
   localparam int unsigned WLW  = $clog2(DW) + 1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              start_bit,
   input logic              busy,
   input logic              lock,
   input logic [PW-1:0]     half,
   input logic [WLW-1:0]    wlen,
   input logic [LINES-1:0]  csmask,
   input logic              sck_raw,
   input logic              sdo_raw,
   input logic              cs_raw
);
   // R3
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && reg_we && reg_addr == A_CTRL && start_bit && !lock) |=> busy);

   // R10
   lock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && reg_we && reg_addr == A_CTRL && start_bit && lock) |=> !busy);

   // R9
   busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_we) |=> ($stable(half) && $stable(wlen) && $stable(csmask) && $stable(lock)));

   // R4
   cs_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_raw) |-> (cs_raw && $past(cs_raw)));

   // R5
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_raw && $past(sck_raw)) |-> $stable(sdo_raw));

   // R11
   wlen_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wlen >= WLW'(1)) && (wlen <= WLW'(DW)));
endmodule

bind spi_cmd_master spi_cmd_chk #(.LINES(LINES), .DW(DW), .PW(PW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .start_bit(reg_wdata[31]), .busy(busy), .lock(lock), .half(half),
   .wlen(wlen), .csmask(csmask), .sck_raw(sck_raw), .sdo_raw(sdo_raw),
   .cs_raw(cs_raw)
);

// File: tb/sim_spi_cmd_master.sv
module sim_spi_cmd_master;
   logic        clk = 1'b0;
   logic        rst_n, reg_we, spi_sdi;
   logic [4:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic [14:0] spi_sck, spi_sdo, spi_cs;
   logic        spi_clr, busy;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic [31:0] slot_m [16];
   int          wlen_m = 32, half_m = 7;
   logic [14:0] csm_m = '0;
   logic [31:0] sdoc_m = '0, sckc_m = '0, csc_m = '0;
   logic [31:0] last_pat;

   always #4 clk = ~clk;

   spi_cmd_master u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sdi(spi_sdi),
      .spi_sck(spi_sck), .spi_sdo(spi_sdo), .spi_cs(spi_cs),
      .spi_clr(spi_clr), .busy(busy)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [14:0] lines(input logic [14:0] raw, input logic [31:0] c);
      return (raw & ~c[14:0]) ^ c[30:16];
   endfunction

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
      reg_addr = a;
      #1;
      chk(tag, 64'(reg_rdata), 64'(exp));
   endtask

   function automatic logic [31:0] pattern(input int w);
      return 32'h6B3D_92E1 ^ (32'(w) * 32'h1357_9BDF);
   endfunction

   // behavioural model of one sequence, compared on every clock
   task automatic run_seq(input int cnt, input bit poke);
      int n = wlen_m;
      logic [63:0] nmask = (64'd1 << n) - 64'd1;
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 5'h11; reg_wdata = 32'h8000_0000 | 32'(cnt - 1);
      @(negedge clk);
      reg_we = 1'b0;
      for (int w = 0; w < cnt; w++) begin
         logic [31:0] pat = pattern(w);
         last_pat = pat;
         for (int h = 0; h <= 2 * n + 1; h++) begin
            for (int c = 0; c <= half_m; c++) begin
               int bi = n - 1 - ((h / 2 < n - 1) ? h / 2 : n - 1);
               logic cs_r  = (h <= 2 * n);
               logic sck_r = (h % 2 == 1) && (h < 2 * n);
               logic sdo_r = cs_r && slot_m[w][bi];
               spi_sdi = (h < 2 * n) ? pat[n - 1 - h / 2] : 1'b0;
               if (poke && w == 0 && h == 1 && c == 0) begin
                  reg_we = 1'b1; reg_addr = 5'h1A; reg_wdata = 32'h55;
               end else reg_we = 1'b0;
               #1;
               // R4 R5 R7 R8: all pins and busy against the model
               chk($sformatf("R4/R5/R7/R8 pins w%0d h%0d c%0d", w, h, c),
                   64'({busy, spi_sck, spi_sdo, spi_cs}),
                   64'({1'b1, lines({15{sck_r}}, sckc_m), lines({15{sdo_r}}, sdoc_m),
                        lines({15{cs_r}} & csm_m, csc_m)}));
               @(negedge clk);
            end
         end
      end
      reg_we = 1'b0;
      #1;
      chk("R3 sequence end idle", 64'({busy, spi_sck, spi_sdo, spi_cs}),
          64'({1'b0, lines('0, sckc_m), lines('0, sdoc_m), lines('0, csc_m)}));
      rd(5'h12, 32'(64'(last_pat) & nmask), "R6 readback");
      if (poke) rd(5'h1A, 32'(half_m), "R9 write during busy ignored");
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; spi_sdi = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pins and busy", 64'({busy, spi_sck, spi_sdo, spi_cs}), 64'd0);
      rd(5'h19, 32'd32, "R1 word length");
      rd(5'h1A, 32'd7, "R1 half period");
      rd(5'h11, 32'd0, "R1 control");
      rd(5'h10, 32'd0, "R1 cs mask");
      rd(5'h16, 32'd0, "R1 sck control");

      // R2 slot storage; high bits set to expose R5 truncation
      for (int s = 0; s < 16; s++) begin
         slot_m[s] = 32'hF0A5_0000 ^ (32'(s) * 32'h0101_3C97);
         wr(5'(s), slot_m[s]);
      end
      for (int s = 0; s < 16; s++) rd(5'(s), slot_m[s], "R2 slot readback");

      // R11 word length range
      wr(5'h19, 32'd8); wlen_m = 8;
      wr(5'h19, 32'd0);
      rd(5'h19, 32'd8, "R11 zero length ignored");
      wr(5'h19, 32'd33);
      rd(5'h19, 32'd8, "R11 oversize length ignored");
      wr(5'h1A, 32'h1FF); half_m = 32'hFF;
      rd(5'h1A, 32'hFF, "R11 half period width");
      wr(5'h1A, 32'd1); half_m = 1;

      // R7 sequence A: three 8-bit words on lines 0 and 2
      wr(5'h10, 32'h0005); csm_m = 15'h0005;
      run_seq(3, 1'b0);

      // R8 sequence B: 32 bits, fastest clock, mixed line controls, R9 poke
      wr(5'h19, 32'd32); wlen_m = 32;
      wr(5'h1A, 32'd0); half_m = 0;
      wr(5'h10, 32'h7FF0); csm_m = 15'h7FF0;
      wr(5'h15, 32'h0000_0002); sdoc_m = 32'h0000_0002;
      wr(5'h16, 32'h0004_0000); sckc_m = 32'h0004_0000;
      wr(5'h17, 32'h0011_0010); csc_m = 32'h0011_0010;
      rd(5'h17, 32'h0011_0010, "R8 cs control readback");
      run_seq(1, 1'b1);

      // R3 sequence C: all sixteen slots, 5-bit words
      wr(5'h19, 32'd5); wlen_m = 5;
      wr(5'h1A, 32'd2); half_m = 2;
      run_seq(16, 1'b0);
      rd(5'h11, 32'h0000_000F, "R3 control count after run");

      // R10 lock blocks start
      wr(5'h13, 32'd1);
      rd(5'h13, 32'd1, "R10 lock readback");
      wr(5'h11, 32'h8000_0000);
      repeat (4) begin
         @(negedge clk); #1;
         chk("R10 no start while locked", 64'({busy, spi_sck, spi_sdo, spi_cs}),
             64'({1'b0, lines('0, sckc_m), lines('0, sdoc_m), lines('0, csc_m)}));
      end
      wr(5'h13, 32'd0);

      // R12 clear output
      wr(5'h14, 32'd1); #1;
      chk("R12 clear high", 64'(spi_clr), 64'd1);
      wr(5'h14, 32'd0); #1;
      chk("R12 clear low", 64'(spi_clr), 64'd0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule